// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches a processor bus one cycle at a time and raises a one-clock break request when a bus cycle meets a condition that software has programmed. It has two channels, A and B. Each channel compares the cycle address against a 32-bit target, using one of four coded mask widths. It also qualifies the cycle on four two-bit attributes: who drives the bus, instruction fetch or data access, read or write, and operand size. When a channel matches, it records which kind of master was involved in a sticky flag. Software clears that flag by writing zero to it.

Software programs the channels through a plain write/read register port. Writes take effect on the next clock, and reads are combinational. A sequencing state machine lets the two channels work on their own, or makes channel B wait until channel A has matched first. The sequencing machine has three states:

- `SQ_FREE`: the sequential bit is off.
- `SQ_WAIT_A`: the sequential bit is on and no channel A match has been seen yet.
- `SQ_ARMED`: channel A has matched and the machine is waiting for channel B.

It has five transitions:

- FREE→WAIT_A when the sequential bit is on and there is no A hit.
- FREE/WAIT_A→ARMED on an A hit while the sequential bit is on.
- ARMED→WAIT_A on a B hit, which is the cycle that raises the break.
- ARMED→ARMED while waiting.
- Any state→FREE whenever the sequential bit is off.

Top module: `bkpt_match_top`

## Requirements
- R1: After reset every register reads 0 and no bus cycle causes a break request.
- R2: Mask code (bits 1:0 of the mask register): 0 compares all 32 address bits, 1 ignores address bits 9:0, 2 ignores bits 11:0, 3 ignores every address bit.
- R3: Master qualifier is condition bits 7:6: 1 matches CPU cycles (`bus_periph`=0), 2 matches peripheral cycles, and both 0 and 3 prevent the channel from ever matching.
- R4: Fetch qualifier is condition bits 5:4: 0 any, 1 instruction fetch (`bus_fetch`=1), 2 data access, 3 never.
- R5: Direction qualifier is condition bits 3:2: 0 any, 1 read (`bus_write`=0), 2 write, 3 never.
- R6: Size qualifier is condition bits 1:0: 0 any, otherwise the value must equal `bus_size` (1 byte, 2 word, 3 longword).
- R7: In non-sequential mode, a matching cycle on either channel drives `brk_req` high for exactly the following clock cycle.
- R8: A match sets the sticky flag for its channel and master in the control register (offset 0x78): A-CPU bit 15, A-peripheral bit 14, B-CPU bit 7, B-peripheral bit 6.
- R9: Flags clear only when software writes 0 to them; writing 1 to a flag never sets it.
- R10: With control bit 4 set, a channel A match sets its flag but raises no break, and a later channel B match raises one break and re-arms the wait for A; B matches with no A match recorded raise nothing.
- R11: Register offsets are: channel A address 0x40, mask 0x44, condition 0x48; channel B at 0x60, 0x64, 0x68; control 0x78. Mask reads back only bits 1:0, condition only bits 7:0, and control only its defined bits (writable non-flag set 0x341C). Unused offsets read 0.
- R12: A cycle with `bus_valid` low never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Bus cycle address |
| bus_periph | input | 1 | 1 = peripheral master, 0 = CPU |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size: 1 byte, 2 word, 3 longword |
| brk_req | output | 1 | One-clock break request |

## Verification
Addresses are placed just inside and just outside each mask boundary (offsets 0x3FF/0x400 and 0xFFF/0x1000). This shows whether each mask code drops the right number of low bits. Every qualifier value 0 to 3 is tried against both polarities of its attribute. That separates "any", the two selective codes and the never-matching code, and it also shows whether a field is decoded from the wrong bit positions. The sequential tests send a B hit before A, then A, then B twice, which tells apart correct arming, missing arming and failure to re-arm. Flag tests write 0 and 1 patterns to separate clear-only behaviour from plain register writes.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int unsigned AW  = 32;
    localparam int unsigned NCH = 2;
    localparam int unsigned RAW = 8;

    // Register layout (byte offsets)
    localparam logic [RAW-1:0] CH_BASE   = 8'h40;
    localparam int unsigned    CH_STRIDE = 32'h20;
    localparam logic [RAW-1:0] OFS_ADDR  = 8'h00;
    localparam logic [RAW-1:0] OFS_MASK  = 8'h04;
    localparam logic [RAW-1:0] OFS_COND  = 8'h08;
    localparam logic [RAW-1:0] CTRL_OFS  = 8'h78;

    // Control register bits
    localparam int unsigned    SEQ_BIT    = 4;
    localparam logic [15:0]    CTRL_FLAGS = 16'hC0C0;
    localparam logic [15:0]    CTRL_PLAIN = 16'h341C;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic          periph;
        logic          fetch;
        logic          write;
        logic [1:0]    size;
    } bus_cyc_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    mask;
        logic [7:0]    cond;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        SQ_FREE   = 2'd0,
        SQ_WAIT_A = 2'd1,
        SQ_ARMED  = 2'd2
    } seq_st_e;

    function automatic logic [RAW-1:0] ch_base(input int unsigned i);
        return RAW'(32'(CH_BASE) + CH_STRIDE * i);
    endfunction

    // Sticky flag position: channel i, master kind per
    function automatic logic [3:0] flag_bit(input int unsigned i, input logic per);
        return 4'(32'd15 - 32'd8 * i - {31'd0, per});
    endfunction

endpackage

// File: rtl/bkpt_chan_cmp.sv
module bkpt_chan_cmp
    import bkpt_pkg::*;
#(
    parameter int unsigned LOW_MID = 10,
    parameter int unsigned LOW_HI  = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  chan_cfg_t cfg,
    input  bus_cyc_t  bus,
    output logic      hit
);

    localparam logic [AW-1:0] CARE_ALL = '1;
    localparam logic [AW-1:0] CARE_MID = CARE_ALL << LOW_MID;
    localparam logic [AW-1:0] CARE_HI  = CARE_ALL << LOW_HI;

    // Two-choice qualifier: 0 any, 1 first choice, 2 second, 3 never
    function automatic logic pick2(input logic [1:0] q, input logic first);
        case (q)
            2'd0:    return 1'b1;
            2'd1:    return first;
            2'd2:    return !first;
            default: return 1'b0;
        endcase
    endfunction

    logic [AW-1:0] care;
    logic          addr_ok;
    logic          mst_ok;
    logic          kind_ok;
    logic          dir_ok;
    logic          size_ok;

    always_comb begin
        unique case (cfg.mask)
            2'd0: care = CARE_ALL;
            2'd1: care = CARE_MID;
            2'd2: care = CARE_HI;
            2'd3: care = '0;
        endcase
    end

    assign addr_ok = ((bus.addr ^ cfg.addr) & care) == '0;
    assign mst_ok  = (cfg.cond[7:6] != 2'd0) && pick2(cfg.cond[7:6], !bus.periph);
    assign kind_ok = pick2(cfg.cond[5:4], bus.fetch);
    assign dir_ok  = pick2(cfg.cond[3:2], !bus.write);
    assign size_ok = (cfg.cond[1:0] == 2'd0) || (cfg.cond[1:0] == bus.size);

    assign hit = bus.valid && addr_ok && mst_ok && kind_ok && dir_ok && size_ok;

    // R2
    full_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cfg.mask == 2'd0) |-> bus.addr == cfg.addr);

    // R12
    valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> bus.valid);

endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RAW-1:0] addr,
    input  logic [31:0]    wdata,
    input  logic [NCH-1:0] hit,
    input  logic           periph,
    output chan_cfg_t      cfg [NCH],
    output logic           seq_en,
    output logic [31:0]    rdata
);

    logic [15:0] ctrl;
    logic [15:0] ctrl_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int unsigned i = 0; i < NCH; i++) cfg[i] <= '0;
        end else if (we) begin
            for (int unsigned i = 0; i < NCH; i++) begin
                if (addr == ch_base(i) + OFS_ADDR) cfg[i].addr <= wdata;
                if (addr == ch_base(i) + OFS_MASK) cfg[i].mask <= wdata[1:0];
                if (addr == ch_base(i) + OFS_COND) cfg[i].cond <= wdata[7:0];
            end
        end
    end

    always_comb begin
        ctrl_n = ctrl;
        if (we && addr == CTRL_OFS)
            ctrl_n = (wdata[15:0] & CTRL_PLAIN) | (ctrl & wdata[15:0] & CTRL_FLAGS);
        for (int unsigned i = 0; i < NCH; i++)
            if (hit[i]) ctrl_n[flag_bit(i, periph)] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else        ctrl <= ctrl_n;
    end

    assign seq_en = ctrl[SEQ_BIT];

    always_comb begin
        rdata = '0;
        if (addr == CTRL_OFS) rdata = {16'd0, ctrl};
        for (int unsigned i = 0; i < NCH; i++) begin
            if (addr == ch_base(i) + OFS_ADDR) rdata = cfg[i].addr;
            if (addr == ch_base(i) + OFS_MASK) rdata = {30'd0, cfg[i].mask};
            if (addr == ch_base(i) + OFS_COND) rdata = {24'd0, cfg[i].cond};
        end
    end

    // R8
    flag_a_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl[15]) |-> $past(hit[0] && !periph));

    // R8
    flag_b_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl[6]) |-> $past(hit[1] && periph));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl[15]) |-> $past(we && addr == CTRL_OFS && !wdata[15]));

endmodule

// File: rtl/bkpt_seq_fsm.sv
module bkpt_seq_fsm
    import bkpt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           seq_en,
    input  logic [NCH-1:0] hit,
    output logic           brk_req
);

    seq_st_e state;
    seq_st_e nxt;
    logic    brk_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_FREE;
            brk_req <= 1'b0;
        end else begin
            state   <= nxt;
            brk_req <= brk_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        brk_nxt = 1'b0;
        if (!seq_en) begin
            nxt     = SQ_FREE;
            brk_nxt = |hit;
        end else begin
            unique case (state)
                SQ_FREE, SQ_WAIT_A: nxt = hit[0] ? SQ_ARMED : SQ_WAIT_A;
                SQ_ARMED: begin
                    brk_nxt = hit[1];
                    nxt     = hit[1] ? SQ_WAIT_A : SQ_ARMED;
                end
                default: nxt = SQ_FREE;
            endcase
        end
    end

    // R7
    brk_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(|hit));

    // R10
    arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ARMED) |-> ($past(hit[0]) || $past(state == SQ_ARMED)));

endmodule

// File: rtl/bkpt_match_top.sv
module bkpt_match_top
    import bkpt_pkg::*;
#(
    parameter int unsigned LOW_MID = 10,
    parameter int unsigned LOW_HI  = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        bus_valid,
    input  logic [31:0] bus_addr,
    input  logic        bus_periph,
    input  logic        bus_fetch,
    input  logic        bus_write,
    input  logic [1:0]  bus_size,
    output logic        brk_req
);

    bus_cyc_t       bus;
    chan_cfg_t      cfg [NCH];
    logic [NCH-1:0] hit;
    logic           seq_en;

    assign bus = {bus_valid, bus_addr, bus_periph, bus_fetch, bus_write, bus_size};

    bkpt_regs regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .hit    (hit),
        .periph (bus_periph),
        .cfg    (cfg),
        .seq_en (seq_en),
        .rdata  (reg_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        bkpt_chan_cmp #(
            .LOW_MID (LOW_MID),
            .LOW_HI  (LOW_HI)
        ) cmp_i (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg[g]),
            .bus   (bus),
            .hit   (hit[g])
        );
    end

    bkpt_seq_fsm fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .seq_en  (seq_en),
        .hit     (hit),
        .brk_req (brk_req)
    );

    // R12
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(bus_valid));

    // R10
    seq_b_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_req && $past(seq_en)) |-> $past(hit[1]));

endmodule

// File: tb/bkpt_match_top_tb.sv
module bkpt_match_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_periph = 1'b0;
    logic        bus_fetch = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = '0;
    logic        brk_req;

    int checks = 0;
    int failures = 0;

    // behavioural model state
    logic [31:0] m_addr [2];
    logic [1:0]  m_mask [2];
    logic [7:0]  m_cond [2];
    logic [15:0] m_ctrl;
    bit          m_arm;

    localparam logic [31:0] P = 32'h0600_1000;
    localparam logic [31:0] Q = 32'h2000_0040;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_match_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_periph(bus_periph), .bus_fetch(bus_fetch),
        .bus_write(bus_write), .bus_size(bus_size), .brk_req(brk_req)
    );

    function automatic bit m_hit(int ch, bit v, logic [31:0] ba, bit per,
                                 bit fet, bit wr, logic [1:0] sz);
        int cpa = int'(m_cond[ch][7:6]);
        int ida = int'(m_cond[ch][5:4]);
        int rwa = int'(m_cond[ch][3:2]);
        int sza = int'(m_cond[ch][1:0]);
        int ign;
        if (!v || cpa == 0) return 0;
        if (cpa != (per ? 2 : 1)) return 0;
        if (ida != 0 && ida != (fet ? 1 : 2)) return 0;
        if (rwa != 0 && rwa != (wr ? 2 : 1)) return 0;
        if (sza != 0 && sza != int'(sz)) return 0;
        ign = (m_mask[ch] == 0) ? 0 : (m_mask[ch] == 1) ? 10 : (m_mask[ch] == 2) ? 12 : 32;
        if (ign < 32 && ((ba ^ m_addr[ch]) >> ign) != 0) return 0;
        return 1;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(string tag, bit we, logic [7:0] a, logic [31:0] d, bit v,
                       logic [31:0] ba, bit per, bit fet, bit wr, logic [1:0] sz);
        bit ha, hb, exp;
        reg_we = we; reg_addr = a; reg_wdata = d;
        bus_valid = v; bus_addr = ba; bus_periph = per;
        bus_fetch = fet; bus_write = wr; bus_size = sz;
        ha = m_hit(0, v, ba, per, fet, wr, sz);
        hb = m_hit(1, v, ba, per, fet, wr, sz);
        if (!m_ctrl[4]) begin
            exp = ha | hb; m_arm = 0;
        end else if (m_arm) begin
            exp = hb; if (hb) m_arm = 0;
        end else begin
            exp = 0; if (ha) m_arm = 1;
        end
        if (we) begin
            case (a)
                8'h40: m_addr[0] = d;
                8'h44: m_mask[0] = d[1:0];
                8'h48: m_cond[0] = d[7:0];
                8'h60: m_addr[1] = d;
                8'h64: m_mask[1] = d[1:0];
                8'h68: m_cond[1] = d[7:0];
                8'h78: m_ctrl = (d[15:0] & 16'h341C) | (m_ctrl & d[15:0] & 16'hC0C0);
                default: ;
            endcase
        end
        if (ha) m_ctrl[per ? 14 : 15] = 1'b1;
        if (hb) m_ctrl[per ? 6 : 7] = 1'b1;
        @(posedge clk); #1;
        check(tag, {31'd0, brk_req}, {31'd0, exp});
        reg_we = 0; bus_valid = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        cyc("R11 write", 1, a, d, 0, '0, 0, 0, 0, 2'd0);
    endtask

    task automatic bus(string tag, logic [31:0] ba, bit per, bit fet, bit w, logic [1:0] sz);
        cyc(tag, 0, 8'h00, '0, 1, ba, per, fet, w, sz);
    endtask

    task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
        reg_we = 0; reg_addr = a; #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_addr = '{default: '0}; m_mask = '{default: '0};
        m_cond = '{default: '0}; m_ctrl = '0; m_arm = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd("R1 addrA", 8'h40, 0); rd("R1 maskA", 8'h44, 0); rd("R1 condA", 8'h48, 0);
        rd("R1 addrB", 8'h60, 0); rd("R1 condB", 8'h68, 0); rd("R1 ctrl", 8'h78, 0);
        bus("R1 no break", P, 0, 1, 0, 2'd2);
        bus("R1 no break", 32'h0, 1, 0, 1, 2'd3);

        // R7: basic match on channel A
        wr(8'h40, P); wr(8'h48, 32'h40);
        rd("R11 addrA", 8'h40, P);
        bus("R7 hit", P, 0, 1, 0, 2'd2);
        cyc("R7 pulse ends", 0, 0, 0, 0, '0, 0, 0, 0, 2'd0);
        cyc("R12 invalid", 0, 0, 0, 0, P, 0, 1, 0, 2'd2);
        rd("R8 flag A cpu", 8'h78, 32'h8000);

        // R2: mask modes
        bus("R2 mask0 miss", P + 2, 0, 1, 0, 2'd2);
        wr(8'h44, 1);
        bus("R2 mask1 hit", P + 32'h3FF, 0, 1, 0, 2'd2);
        bus("R2 mask1 miss", P + 32'h400, 0, 1, 0, 2'd2);
        wr(8'h44, 2);
        bus("R2 mask2 hit", P + 32'hFFF, 0, 1, 0, 2'd2);
        bus("R2 mask2 miss", P + 32'h1000, 0, 1, 0, 2'd2);
        wr(8'h44, 3);
        bus("R2 mask3 hit", 32'hDEAD_0000, 0, 0, 1, 2'd1);
        wr(8'h44, 0);

        // R3: master qualifier
        wr(8'h48, 32'h80);
        bus("R3 per-only cpu", P, 0, 1, 0, 2'd2);
        bus("R3 per-only per", P, 1, 1, 0, 2'd2);
        rd("R8 flags A both", 8'h78, 32'hC000);
        wr(8'h48, 32'hC0);
        bus("R3 code3 cpu", P, 0, 1, 0, 2'd2);
        bus("R3 code3 per", P, 1, 1, 0, 2'd2);

        // R9: clear-only flags
        wr(8'h78, 32'h4000);
        rd("R9 clear bit15", 8'h78, 32'h4000);
        wr(8'h78, 32'hC000);
        rd("R9 write1 no set", 8'h78, 32'h4000);
        wr(8'h78, 32'h0);
        rd("R9 all clear", 8'h78, 32'h0);

        // R4, R5, R6: qualifier sweeps
        for (int q = 0; q < 4; q++) begin
            wr(8'h48, 32'h40 | (q << 4));
            bus("R4 fetch", P, 0, 1, 0, 2'd2);
            bus("R4 data", P, 0, 0, 0, 2'd2);
        end
        for (int q = 0; q < 4; q++) begin
            wr(8'h48, 32'h40 | (q << 2));
            bus("R5 read", P, 0, 0, 0, 2'd3);
            bus("R5 write", P, 0, 0, 1, 2'd3);
        end
        for (int q = 0; q < 4; q++) begin
            wr(8'h48, 32'h40 | q);
            for (int s = 1; s < 4; s++) bus("R6 size", P, 0, 0, 0, 2'(s));
        end
        wr(8'h48, 32'h40);
        wr(8'h78, 32'h0);

        // R8: channel B flag
        wr(8'h60, Q); wr(8'h68, 32'h88);
        bus("R8 B hit", Q, 1, 0, 1, 2'd3);
        bus("R5 B read miss", Q, 1, 0, 0, 2'd3);
        rd("R8 flag B per", 8'h78, 32'h0040);

        // R10: sequential mode
        wr(8'h78, 32'h0010);
        bus("R10 B before A", Q, 1, 0, 1, 2'd3);
        bus("R10 A arms", P, 0, 1, 0, 2'd2);
        bus("R10 B breaks", Q, 1, 0, 1, 2'd3);
        bus("R10 B rearmed", Q, 1, 0, 1, 2'd3);
        rd("R10 flags", 8'h78, 32'h80D0 & 32'h80D0 & ~32'h0080);

        // R11: widths and unused offsets
        wr(8'h78, 32'h0);
        wr(8'h64, 32'hFFFF_FFFF);
        rd("R11 mask width", 8'h64, 32'h3);
        wr(8'h68, 32'hFFFF);
        rd("R11 cond width", 8'h68, 32'hFF);
        wr(8'h78, 32'hFFFF);
        rd("R11 ctrl width", 8'h78, 32'h341C);
        rd("R11 unused 0x50", 8'h50, 32'h0);
        rd("R11 unused 0x4C", 8'h4C, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule